// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a 32-bit load/store pipeline stage. Each request names one of four address forms: a decrement of the base register before the access, a short unsigned offset from the base register, the sum of the base register and an index register, or a wider unsigned offset from a global base value. Both offsets are scaled by the access width: byte, halfword (called "word" here) or longword.

The block registers its results. A request presented in one cycle yields an address one clock later. For the decrement form the block also produces the updated register value and a one-cycle write strobe, so the register file can store it. The address sent to memory is the value after the decrement.

Top module: `eag_top`

## Requirements
- R1: With `mode` = 2'b00 (pre-decrement), `ea` equals `reg_val` minus 1, 2 or 4 for byte, word or longword, modulo 2^32.
- R2: A pre-decrement request raises `wb_en` for exactly the one result cycle, and `wb_data` equals `ea` in that cycle. In the other three modes `wb_en` stays low.
- R3: With `mode` = 2'b01, `ea` equals `reg_val` plus `disp[3:0]`, zero-extended and multiplied by 1, 2 or 4 according to size. `disp[7:4]` has no effect on the result.
- R4: With `mode` = 2'b10, `ea` equals `reg_val + idx_val`, whatever the size and `disp`.
- R5: With `mode` = 2'b11, `ea` equals `base_val` plus `disp[7:0]`, zero-extended and multiplied by 1, 2 or 4 according to size.
- R6: `size` selects the access width: 2'b00 is byte, 2'b01 is word, 2'b10 is longword, and 2'b11 behaves as longword.
- R7: All sums and differences wrap modulo 2^32, with no overflow indication.
- R8: `ea_vld` is high in the cycle after a clock edge at which `req_vld` was high, and low after an edge at which it was low.
- R9: While `rst_n` is low at a clock edge, `ea_vld`, `wb_en`, `ea` and `wb_data` are cleared to zero.
- R10: An edge with `req_vld` low leaves `ea` and `wb_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| mode | input | 2 | Address form select |
| size | input | 2 | Access width code |
| reg_val | input | 32 | Base register value |
| idx_val | input | 32 | Index register value |
| base_val | input | 32 | Global base value |
| disp | input | 8 | Offset field (low 4 bits used in mode 2'b01) |
| ea_vld | output | 1 | Address valid |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Register write strobe |
| wb_data | output | 32 | Updated register value |

## Verification
All four results (`ea`, `ea_vld`, `wb_en` and `wb_data`) are due one clock edge after the request edge, and none is due earlier. The bench changes inputs on the falling edge. It samples one nanosecond after the next rising edge, so each check reads the registers that the request edge loaded. After every request the bench inserts an idle edge with the inputs scrambled. It then confirms that the valid and strobe signals have dropped and that the held address has not moved.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int EA_W = 32;
  typedef logic [EA_W-1:0] addr_t;

  typedef enum logic [1:0] {
    AM_PREDEC = 2'b00,
    AM_DISP4  = 2'b01,
    AM_INDEX  = 2'b10,
    AM_BASE8  = 2'b11
  } amode_e;

  // Width code to shift amount; code 3 maps to the longword shift.
  function automatic logic [1:0] size_shamt(input logic [1:0] sz);
    case (sz)
      2'b00:   size_shamt = 2'd0;
      2'b01:   size_shamt = 2'd1;
      default: size_shamt = 2'd2;
    endcase
  endfunction

  function automatic addr_t scale_off(input addr_t zext, input logic [1:0] sh);
    scale_off = zext << sh;
  endfunction

  function automatic addr_t size_step(input logic [1:0] sh);
    size_step = addr_t'(1) << sh;
  endfunction
endpackage

// File: rtl/eag_scale.sv
module eag_scale
  import eag_pkg::*;
#(
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic [1:0]        size,
  input  logic [DISP_W-1:0] disp,
  output addr_t             short_off,
  output addr_t             long_off,
  output addr_t             step
);
  logic [1:0] sh;
  addr_t      short_zx;
  addr_t      long_zx;

  assign sh = size_shamt(size);

  generate
    if (SHORT_W < DISP_W) begin : g_trunc
      assign short_zx = addr_t'(disp[SHORT_W-1:0]);
    end else begin : g_full
      assign short_zx = addr_t'(disp);
    end
  endgenerate

  assign long_zx   = addr_t'(disp);
  assign short_off = scale_off(short_zx, sh);
  assign long_off  = scale_off(long_zx, sh);
  assign step      = size_step(sh);
endmodule

// File: rtl/eag_addr.sv
module eag_addr
  import eag_pkg::*;
(
  input  amode_e mode,
  input  addr_t  reg_val,
  input  addr_t  idx_val,
  input  addr_t  base_val,
  input  addr_t  short_off,
  input  addr_t  long_off,
  input  addr_t  step,
  output addr_t  ea_next,
  output addr_t  wb_next,
  output logic   is_predec
);
  assign wb_next   = reg_val - step;
  assign is_predec = (mode == AM_PREDEC);

  always_comb begin
    case (mode)
      AM_PREDEC: ea_next = wb_next;
      AM_DISP4:  ea_next = reg_val + short_off;
      AM_INDEX:  ea_next = reg_val + idx_val;
      default:   ea_next = base_val + long_off;
    endcase
  end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg
  import eag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_vld,
  input  logic  is_predec,
  input  addr_t ea_next,
  input  addr_t wb_next,
  output logic  ea_vld,
  output addr_t ea,
  output logic  wb_en,
  output addr_t wb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_vld  <= 1'b0;
      wb_en   <= 1'b0;
      ea      <= '0;
      wb_data <= '0;
    end else begin
      ea_vld <= req_vld;
      wb_en  <= req_vld & is_predec;
      if (req_vld) begin
        ea      <= ea_next;
        wb_data <= wb_next;
      end
    end
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [31:0]       reg_val,
  input  logic [31:0]       idx_val,
  input  logic [31:0]       base_val,
  input  logic [DISP_W-1:0] disp,
  output logic              ea_vld,
  output logic [31:0]       ea,
  output logic              wb_en,
  output logic [31:0]       wb_data
);
  addr_t short_off, long_off, step;
  addr_t ea_next, wb_next;
  logic  is_predec;

  eag_scale #(.DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_scale (
    .size(size), .disp(disp),
    .short_off(short_off), .long_off(long_off), .step(step)
  );

  eag_addr u_addr (
    .mode(amode_e'(mode)), .reg_val(reg_val), .idx_val(idx_val),
    .base_val(base_val), .short_off(short_off), .long_off(long_off),
    .step(step), .ea_next(ea_next), .wb_next(wb_next), .is_predec(is_predec)
  );

  eag_outreg u_out (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .is_predec(is_predec),
    .ea_next(ea_next), .wb_next(wb_next),
    .ea_vld(ea_vld), .ea(ea), .wb_en(wb_en), .wb_data(wb_data)
  );
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
  parameter int DISP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [1:0]        mode,
  input logic [1:0]        size,
  input logic [31:0]       reg_val,
  input logic [31:0]       idx_val,
  input logic [DISP_W-1:0] disp,
  input logic              ea_vld,
  input logic [31:0]       ea,
  input logic              wb_en,
  input logic [31:0]       wb_data
);
  logic [31:0] dec_amt;
  always_comb begin
    case (size)
      2'b00:   dec_amt = 32'd1;
      2'b01:   dec_amt = 32'd2;
      default: dec_amt = 32'd4;
    endcase
  end

  assert_predec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && req_vld && mode == 2'b00 |=> ea == $past(reg_val) - $past(dec_amt));

  assert_wb_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ea_vld && wb_data == ea);

  assert_wb_only_predec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && req_vld && mode != 2'b00 |=> !wb_en);

  assert_index_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && req_vld && mode == 2'b10 |=> ea == $past(reg_val) + $past(idx_val));

  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !req_vld |=> !ea_vld && !wb_en);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> !ea_vld && !wb_en && ea == 32'd0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !req_vld |=> $stable(ea) && $stable(wb_data));

  logic unused_disp;
  assign unused_disp = ^disp;
endmodule

bind eag_top eag_chk #(.DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode), .size(size),
  .reg_val(reg_val), .idx_val(idx_val), .disp(disp),
  .ea_vld(ea_vld), .ea(ea), .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/tb_eag_top.sv
module tb_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  size = 2'b00;
  logic [31:0] reg_val = '0, idx_val = '0, base_val = '0;
  logic [7:0]  disp = '0;
  logic        ea_vld, wb_en;
  logic [31:0] ea, wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eag_top dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode), .size(size),
    .reg_val(reg_val), .idx_val(idx_val), .base_val(base_val), .disp(disp),
    .ea_vld(ea_vld), .ea(ea), .wb_en(wb_en), .wb_data(wb_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (mode %0d size %0d disp %0d)",
               req, act, exp, mode, size, disp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] mult(input logic [1:0] sz);
    return (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] model_ea(input logic [1:0] m, input logic [1:0] sz,
      input logic [31:0] rv, input logic [31:0] iv, input logic [31:0] bv, input logic [7:0] d);
    case (m)
      2'b00:   return rv - mult(sz);
      2'b01:   return rv + {28'd0, d[3:0]} * mult(sz);
      2'b10:   return rv + iv;
      default: return bv + {24'd0, d} * mult(sz);
    endcase
  endfunction

  task automatic one_req(input logic [1:0] m, input logic [1:0] sz, input logic [31:0] rv,
                         input logic [31:0] iv, input logic [31:0] bv, input logic [7:0] d);
    logic [31:0] exp_ea;
    logic [31:0] held_wb;
    string tag;
    @(negedge clk);
    mode = m; size = sz; reg_val = rv; idx_val = iv; base_val = bv; disp = d;
    req_vld = 1'b1;
    exp_ea = model_ea(m, sz, rv, iv, bv, d);
    tag = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R3" : (m == 2'b10) ? "R4" : "R5";
    held_wb = wb_data;
    @(posedge clk); #1;
    chk(tag, ea, exp_ea);
    chk("R8", {31'd0, ea_vld}, 32'd1);
    chk("R2", {31'd0, wb_en}, {31'd0, m == 2'b00});
    if (m == 2'b00) chk("R2", wb_data, exp_ea);
    else held_wb = wb_data;
    // idle edge with scrambled inputs: R8 drop, R10 hold
    @(negedge clk);
    req_vld = 1'b0; mode = ~m; reg_val = ~rv; base_val = ~bv; disp = ~d;
    held_wb = wb_data;
    @(posedge clk); #1;
    chk("R8", {31'd0, ea_vld}, 32'd0);
    chk("R2", {31'd0, wb_en}, 32'd0);
    chk("R10", ea, exp_ea);
    chk("R10", wb_data, held_wb);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rvs [4];
    rvs[0] = 32'h0000_0000; rvs[1] = 32'h0000_0002;
    rvs[2] = 32'hFFFF_FFF0; rvs[3] = 32'h1234_5678;
    // R9: reset state with a request held active
    req_vld = 1'b1; mode = 2'b11; disp = 8'hFF; base_val = 32'hDEAD_0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", {31'd0, ea_vld}, 32'd0);
    chk("R9", {31'd0, wb_en}, 32'd0);
    chk("R9", ea, 32'd0);
    chk("R9", wb_data, 32'd0);
    @(negedge clk); req_vld = 1'b0; rst_n = 1'b1;

    // R1, R2, R6, R7: decrement near zero wraps
    for (int s = 0; s < 4; s++) one_req(2'b00, 2'(s), 32'd1, 32'd0, 32'd0, 8'd0);
    // R4, R7: index sum wraps, size/disp ignored
    for (int s = 0; s < 4; s++)
      one_req(2'b10, 2'(s), 32'hFFFF_FFFF, 32'd5, 32'h5555_5555, 8'hA5);
    // sweep: every mode, size, offset, several base values
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 256; d += ((m == 2'b01 || m == 2'b11) ? 1 : 37))
            one_req(2'(m), 2'(s), rvs[r], rvs[3-r] ^ 32'h0F0F_0000,
                    32'hFFFF_FF00 + rvs[r], 8'(d));
    finish_run();
  end
endmodule